// File: doc/BRIEF.md
# Dual-Clock Johnson Decade Counter

This block counts through ten states held in a five-stage twisted-ring register. It drives a one-hot bus of ten decoded lines and a `lower_half` line that is high for the first five states and low for the last five. Two level inputs, `tick_a` and `tick_b`, are sampled on the system clock `clk`. The count moves on a rising edge of `tick_a` while `tick_b` is low, or on a falling edge of `tick_b` while `tick_a` is high. Either input can therefore act as the clock, with the other acting as an enable of the matching polarity.

A high level on `clear` takes effect at once, without waiting for `clk`. It returns the block to state 0 and overrides both tick inputs. Counters can be chained: the `lower_half` line of one stage feeds `tick_a` of the next, and it rises exactly when the first stage wraps from 9 to 0.

Both tick inputs pass through a two-flop synchroniser. An edge is found by comparing each synchronised value with its value one cycle earlier. A tick change reaches the outputs on the fourth rising edge of `clk` after the change. Unused ring patterns are cleared to state 0 on the next advance.

Top module: `decade_ring_counter`

## Requirements
- R1: While `clear` is high, `hot` equals 10'b0000000001 and `lower_half` is 1, whatever the tick inputs do. Raising `clear` between clock edges changes the outputs without waiting for a `clk` edge.
- R2: A rising edge on `tick_a` while `tick_b` is low advances the count by exactly one.
- R3: A falling edge on `tick_b` while `tick_a` is high advances the count by exactly one.
- R4: Each of the following leaves the count unchanged: a rising edge of `tick_a` while `tick_b` is high, a falling edge of `tick_b` while `tick_a` is low, a falling edge of `tick_a`, and a rising edge of `tick_b`.
- R5: When both qualifying conditions appear in the same sampled cycle (`tick_a` rises and `tick_b` falls together), the count advances once.
- R6: Bit k of `hot` is the only bit high in state k. After ten advances from state 9 back round, state 9 is followed by state 0.
- R7: `lower_half` is 1 in states 0 to 4 and 0 in states 5 to 9. When it drives `tick_a` of a second counter whose `tick_b` is 0, the second counter advances once per wrap of the first.
- R8: Releasing `clear` while `tick_a` is already high and `tick_b` is low causes no advance.
- R9: If the ring register holds an unused pattern, the next advance puts it in state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock on which the tick inputs are sampled |
| clear | input | 1 | Asynchronous, active-high master reset to state 0 |
| tick_a | input | 1 | Counts on its rising edge while `tick_b` is low |
| tick_b | input | 1 | Counts on its falling edge while `tick_a` is high |
| hot | output | 10 | One-hot decoded state; bit k is high in state k |
| lower_half | output | 1 | High in states 0 to 4, low in states 5 to 9 |

## Verification
The counter is first driven with a short mixed sequence of level pairs. This sequence separates the two qualifying edges from their mirror images with the gating input at the wrong level, and from the case where both inputs change in one sample. Two full laps follow, one with `tick_a` as the clock and one with `tick_b` as the clock. Each lap checks every decoded position and the `lower_half` boundary between states 4 and 5. A chained second counter shows whether `lower_half` rises only on the wrap. Directed cases cover a mid-cycle clear, release of clear with `tick_a` already high, and a forced unused ring pattern that must fall back to state 0.

// File: rtl/ring_pkg.sv
package ring_pkg;

  // Sampled levels of the two tick inputs.
  typedef struct packed {
    logic a_lvl;
    logic b_lvl;
  } tick_pair_t;

  // Number of adjacent bit pairs that differ in the low n bits.
  // A valid twisted-ring state has at most one such boundary.
  function automatic int ring_steps(input logic [31:0] v, input int n);
    int cnt;
    cnt = 0;
    for (int i = 0; i < 31; i++) begin
      if (i < n - 1 && v[i] != v[i+1]) cnt++;
    end
    return cnt;
  endfunction

endpackage

// File: rtl/ring_edge_qual.sv
module ring_edge_qual
  import ring_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic clear,
  input  logic a_i,
  input  logic b_i,
  output logic adv_o
);

  localparam int ARM_W = SYNC_STAGES + 1;

  tick_pair_t       sync_q [SYNC_STAGES];
  tick_pair_t       hist_q;
  tick_pair_t       now_s;
  logic [ARM_W-1:0] arm_q;
  logic             a_rise;
  logic             b_fall;

  // Synchroniser chain, one register per stage.
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or posedge clear) begin
          if (clear) sync_q[0] <= '0;
          else       sync_q[0] <= {a_i, b_i};
        end
      end else begin : g_next
        always_ff @(posedge clk or posedge clear) begin
          if (clear) sync_q[g] <= '0;
          else       sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign now_s = sync_q[SYNC_STAGES-1];

  // History and arming: edges are ignored until the whole chain holds real samples.
  always_ff @(posedge clk or posedge clear) begin
    if (clear) begin
      hist_q <= '0;
      arm_q  <= '0;
    end else begin
      hist_q <= now_s;
      arm_q  <= {arm_q[ARM_W-2:0], 1'b1};
    end
  end

  always_comb begin
    a_rise = now_s.a_lvl & ~hist_q.a_lvl & ~now_s.b_lvl;
    b_fall = now_s.a_lvl &  hist_q.b_lvl & ~now_s.b_lvl;
    adv_o  = arm_q[ARM_W-1] & (a_rise | b_fall);
  end

  // A tick_b held high blocks every advance.
  AST_B_HIGH_BLOCKS: assert property (@(posedge clk) disable iff (clear)
    (now_s.b_lvl && hist_q.b_lvl) |-> !adv_o); // R4

  // A falling tick_a while tick_b stays low never advances.
  AST_A_FALL_IGNORED: assert property (@(posedge clk) disable iff (clear)
    (!now_s.a_lvl && hist_q.a_lvl && !now_s.b_lvl && !hist_q.b_lvl) |-> !adv_o); // R4

endmodule

// File: rtl/ring_state_reg.sv
module ring_state_reg
  import ring_pkg::*;
#(
  parameter int STAGES = 5
) (
  input  logic              clk,
  input  logic              clear,
  input  logic              adv_i,
  output logic [STAGES-1:0] state_o
);

  logic [STAGES-1:0] state_q;
  logic [STAGES-1:0] next_s;
  logic              legal_s;

  always_comb begin
    legal_s = (ring_steps(32'(state_q), STAGES) <= 1);
    if (legal_s) next_s = {state_q[STAGES-2:0], ~state_q[STAGES-1]};
    else         next_s = '0;
  end

  always_ff @(posedge clk or posedge clear) begin
    if (clear)      state_q <= '0;
    else if (adv_i) state_q <= next_s;
  end

  assign state_o = state_q;

  // Every advance lands on a valid ring pattern.
  AST_STEP_LANDS_LEGAL: assert property (@(posedge clk) disable iff (clear)
    adv_i |=> (ring_steps(32'(state_q), STAGES) <= 1)); // R9

endmodule

// File: rtl/ring_decode.sv
module ring_decode
  import ring_pkg::*;
#(
  parameter int STAGES = 5
) (
  input  logic                clk,
  input  logic                clear,
  input  logic [STAGES-1:0]   state_i,
  output logic [2*STAGES-1:0] hot_o,
  output logic                low_o
);

  localparam int COUNT = 2 * STAGES;

  logic [COUNT-1:0] hit_s;
  logic [COUNT-1:0] hot_q;
  logic             low_q;
  logic             legal_s;

  // Each state is recognised from one adjacent bit pair.
  genvar k;
  generate
    for (k = 0; k < STAGES; k++) begin : g_pair
      if (k == 0) begin : g_ends
        assign hit_s[0]      = ~state_i[STAGES-1] & ~state_i[0];
        assign hit_s[STAGES] =  state_i[STAGES-1] &  state_i[0];
      end else begin : g_mid
        assign hit_s[k]          =  state_i[k-1] & ~state_i[k];
        assign hit_s[STAGES + k] = ~state_i[k-1] &  state_i[k];
      end
    end
  endgenerate

  always_ff @(posedge clk or posedge clear) begin
    if (clear) begin
      hot_q <= COUNT'(1);
      low_q <= 1'b1;
    end else begin
      hot_q <= hit_s;
      low_q <= ~state_i[STAGES-1];
    end
  end

  assign hot_o   = hot_q;
  assign low_o   = low_q;
  assign legal_s = (ring_steps(32'(state_i), STAGES) <= 1);

  AST_ONE_HOT: assert property (@(posedge clk) disable iff (clear)
    legal_s |=> ($countones(hot_o) == 1)); // R6

  AST_LOW_HALF_MATCH: assert property (@(posedge clk) disable iff (clear)
    ($countones(hot_o) == 1) |-> (low_o == (|hot_o[STAGES-1:0]))); // R7

endmodule

// File: rtl/decade_ring_counter.sv
module decade_ring_counter #(
  parameter int STAGES      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                clear,
  input  logic                tick_a,
  input  logic                tick_b,
  output logic [2*STAGES-1:0] hot,
  output logic                lower_half
);

  logic              adv_w;
  logic [STAGES-1:0] state_w;

  ring_edge_qual #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .clear (clear),
    .a_i   (tick_a),
    .b_i   (tick_b),
    .adv_o (adv_w)
  );

  ring_state_reg #(.STAGES(STAGES)) u_core (
    .clk     (clk),
    .clear   (clear),
    .adv_i   (adv_w),
    .state_o (state_w)
  );

  ring_decode #(.STAGES(STAGES)) u_dec (
    .clk     (clk),
    .clear   (clear),
    .state_i (state_w),
    .hot_o   (hot),
    .low_o   (lower_half)
  );

endmodule

// File: tb/sim_decade_ring_counter.sv
`timescale 1ns/1ps
module sim_decade_ring_counter;

  logic       clk = 1'b0;
  logic       clear = 1'b1;
  logic       ta = 1'b0;
  logic       tb = 1'b0;
  logic [9:0] hot0, hot1;
  logic       low0, low1;
  int         tests = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  decade_ring_counter u0 (.clk(clk), .clear(clear), .tick_a(ta), .tick_b(tb),
                          .hot(hot0), .lower_half(low0));
  // Chained stage: first stage's lower_half clocks it.
  decade_ring_counter u1 (.clk(clk), .clear(clear), .tick_a(low0), .tick_b(1'b0),
                          .hot(hot1), .lower_half(low1));

  // Table bits: [5]=tick_a, [4]=tick_b, [3:0]=expected state afterwards.
  localparam int NV = 13;
  localparam logic [5:0] TBL [NV] = '{
    6'b10_0001,  // R2 rise of a, b low
    6'b00_0001,  // R4 fall of a
    6'b10_0010,  // R2
    6'b11_0010,  // R4 rise of b
    6'b10_0011,  // R3 fall of b, a high
    6'b11_0011,
    6'b01_0011,  // R4 fall of a
    6'b11_0011,  // R4 rise of a while b high
    6'b01_0011,
    6'b00_0011,  // R4 fall of b while a low
    6'b01_0011,
    6'b10_0100,  // R5 both qualify together
    6'b00_0100
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic a, input logic b);
    @(negedge clk);
    ta = a;
    tb = b;
    cyc(6);
  endtask

  task automatic chk(input logic [9:0] h, input logic l, input int exp, input string tag);
    logic [9:0] eh;
    logic       el;
    eh = 10'd1 << exp;
    el = (exp < 5);
    tests++;
    if (h !== eh || l !== el) begin
      fails++;
      $display("FAIL %s: hot=%b low=%b expected hot=%b low=%b", tag, h, l, eh, el);
    end
  endtask

  initial begin
    cyc(4);
    chk(hot0, low0, 0, "R1 reset state");
    @(negedge clk);
    clear = 1'b0;
    cyc(6);

    // Mixed-pattern table
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i][5], TBL[i][4]);
      chk(hot0, low0, int'(TBL[i][3:0]), "R2/R3/R4/R5 table");
    end
    chk(hot1, low1, 0, "R7 no wrap yet");

    // Fresh start
    @(negedge clk); clear = 1'b1; cyc(2); clear = 1'b0; cyc(6);
    chk(hot0, low0, 0, "R1 after clear");

    // Lap clocked by tick_a
    for (int i = 1; i <= 10; i++) begin
      drive(1'b1, 1'b0);
      chk(hot0, low0, i % 10, "R2 R6 R7 lap on tick_a");
      drive(1'b0, 1'b0);
    end
    cyc(10);
    chk(hot1, low1, 1, "R7 cascade after first lap");

    // Lap clocked by tick_b
    drive(1'b0, 1'b1);
    drive(1'b1, 1'b1);
    chk(hot0, low0, 0, "R4 a rises under high b");
    for (int i = 1; i <= 10; i++) begin
      drive(1'b1, 1'b0);
      chk(hot0, low0, i % 10, "R3 R6 R7 lap on tick_b");
      drive(1'b1, 1'b1);
    end
    cyc(10);
    chk(hot1, low1, 2, "R7 cascade after second lap");

    // Asynchronous clear mid-cycle, then release with tick_a high
    drive(1'b1, 1'b0);
    drive(1'b1, 1'b1);
    drive(1'b1, 1'b0);
    chk(hot0, low0, 2, "R3 before clear");
    @(negedge clk);
    #1 clear = 1'b1;
    #1 chk(hot0, low0, 0, "R1 async clear");
    chk(hot1, low1, 0, "R1 async clear second stage");
    cyc(3);
    ta = 1'b1;
    tb = 1'b0;
    cyc(2);
    clear = 1'b0;
    cyc(8);
    chk(hot0, low0, 0, "R8 release with tick_a high");

    // Unused ring pattern
    @(negedge clk);
    force u0.u_core.state_q = 5'b00101;
    @(negedge clk);
    release u0.u_core.state_q;
    drive(1'b1, 1'b1);
    drive(1'b1, 1'b0);
    chk(hot0, low0, 0, "R9 recovery to state 0");
    drive(1'b1, 1'b1);
    drive(1'b1, 1'b0);
    chk(hot0, low0, 1, "R9 counting resumes");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule